// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit sits beside the execute stage of a small 8-bit processor. It receives one already-decoded data-movement operation at a time. With it come the four 16-bit register pairs, the C register, and an 8-bit and a 16-bit immediate. For each operation it works out where memory is touched and in which direction, and whether HL or SP must be rewritten and to what value. It also reports how many machine clock cycles the addressing form costs. The register file, the memory array, fetch and decode live elsewhere; this unit only produces the addresses, strobes and pointer write-backs that those blocks consume.

Operations enter on a valid/ready handshake. The upstream stage holds `in_valid` and the operands steady until it sees `in_ready` high at a rising edge; that edge is the accept. After an accept, `in_ready` stays low until the operation has completed, so upstream must wait. Nothing downstream can stall the unit. Each memory beat lasts exactly one cycle, and the consumer must take it in that cycle. A stack operation moves a 16-bit pair as two byte beats on consecutive cycles: low byte first, at the lower address. The last cycle of every operation carries a one-cycle `done` pulse together with the cost and any pointer write-back.

Top module: `lsu_ea_unit`

## Requirements
- R1: `in_ready` is 1 out of reset and whenever the unit is idle. An accept (`in_valid` and `in_ready` both 1 at a rising edge) drives the first output cycle in the very next cycle. `in_ready` stays 0 from that cycle through the cycle that carries `done`, and it returns to 1 in the cycle after `done`.
- R2: Opcode 0 (register move) completes with cost 4 and opcode 1 (immediate byte to register) completes with cost 8. Both make no memory beat and write back neither HL nor SP. Opcodes 21 to 31 are undefined and behave like opcode 0: cost 4, no beat, no write-back.
- R3: Pointer forms make one beat. Opcode 2 reads at HL and opcode 3 writes at HL. Opcode 5 reads at BC and opcode 6 reads at DE. Opcode 7 writes at BC and opcode 8 writes at DE. All of these cost 8. Opcode 4 writes an immediate byte at HL and costs 12.
- R4: Opcode 9 reads and opcode 10 writes at the 16-bit immediate address, one beat, cost 16.
- R5: Opcode 11 reads and opcode 12 writes at 0xFF00 plus the 8-bit immediate, cost 12. Opcode 13 reads and opcode 14 writes at 0xFF00 plus C, cost 8.
- R6: Opcode 15 reads with HL incremented, 16 reads with HL decremented, 17 writes with HL incremented, and 18 writes with HL decremented. Each makes one beat at the old HL value. `hl_we` pulses with `done`, `hl_val` carries the old HL plus or minus one, and the cost is 8.
- R7: Opcode 19 (push) makes two write beats. The first is at SP-2 with `mem_hi`=0, and the second is at SP-1 with `mem_hi`=1. On the second beat `sp_we` and `done` pulse with `sp_val` = SP-2, and the cost is 16.
- R8: Opcode 20 (pop) makes two read beats, at SP with `mem_hi`=0 and then at SP+1 with `mem_hi`=1. On the second beat `sp_we` and `done` pulse with `sp_val` = SP+2, and the cost is 12.
- R9: All address and pointer arithmetic wraps modulo 65536. This includes the second-beat address, so a beat at 0xFFFF is followed by a beat at 0x0000.
- R10: Single-beat operations raise `done` in the same cycle as their beat, or alone when there is no beat. `done` never lasts more than one cycle. `hl_we` and `sp_we` are only ever 1 together with `done`. While `done` is 0, `cost` reads 0, and while `mem_en` is 0, `mem_addr` reads 0.
- R11: Operands are taken only at the accept. Changing any operand input during a busy operation has no effect on its later beats, write-back values or cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, can accept |
| in_op | input | 5 | Decoded operation code (see R2 to R8) |
| in_bc | input | 16 | BC pair |
| in_de | input | 16 | DE pair |
| in_hl | input | 16 | HL pair |
| in_sp | input | 16 | Stack pointer |
| in_c | input | 8 | C register |
| in_imm8 | input | 8 | 8-bit immediate |
| in_imm16 | input | 16 | 16-bit immediate |
| mem_en | output | 1 | Memory byte beat this cycle |
| mem_wr | output | 1 | Beat is a write (0 = read) |
| mem_addr | output | 16 | Beat byte address |
| mem_hi | output | 1 | Beat carries the high byte of a pair |
| done | output | 1 | Last cycle of the operation |
| hl_we | output | 1 | Write `hl_val` into HL |
| hl_val | output | 16 | New HL value |
| sp_we | output | 1 | Write `sp_val` into SP |
| sp_val | output | 16 | New SP value |
| cost | output | 5 | Cycle cost, valid with `done` |

## Verification
A corrupted phase register shows up within one cycle. `in_ready` comes back early or late, a second `done` appears, or a push or pop loses its high-byte beat. A wrong latched operand or a wrong adder path shows up on the beat itself as a bad `mem_addr`. A wrong write-back shows up as a bad `hl_val` or `sp_val` in the `done` cycle. These are visible one or two cycles after the accept. The wrap cases at 0x0000 and 0xFFFF are driven on purpose, because a carry that leaks past 16 bits only shows there.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 5;
  localparam int COST_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE      = 5'd0,
    OP_IMM8      = 5'd1,
    OP_RD_HL     = 5'd2,
    OP_WR_HL     = 5'd3,
    OP_WR_HL_IMM = 5'd4,
    OP_RD_BC     = 5'd5,
    OP_RD_DE     = 5'd6,
    OP_WR_BC     = 5'd7,
    OP_WR_DE     = 5'd8,
    OP_RD_ABS    = 5'd9,
    OP_WR_ABS    = 5'd10,
    OP_RD_HI_IMM = 5'd11,
    OP_WR_HI_IMM = 5'd12,
    OP_RD_HI_C   = 5'd13,
    OP_WR_HI_C   = 5'd14,
    OP_RD_HL_INC = 5'd15,
    OP_RD_HL_DEC = 5'd16,
    OP_WR_HL_INC = 5'd17,
    OP_WR_HL_DEC = 5'd18,
    OP_PUSH      = 5'd19,
    OP_POP       = 5'd20
  } lsu_op_e;

  localparam logic [COST_W-1:0] COST_REG    = 5'd4;
  localparam logic [COST_W-1:0] COST_IMM8   = 5'd8;
  localparam logic [COST_W-1:0] COST_PTR    = 5'd8;
  localparam logic [COST_W-1:0] COST_HL_IMM = 5'd12;
  localparam logic [COST_W-1:0] COST_ABS    = 5'd16;
  localparam logic [COST_W-1:0] COST_HI_IMM = 5'd12;
  localparam logic [COST_W-1:0] COST_HI_C   = 5'd8;
  localparam logic [COST_W-1:0] COST_PUSH   = 5'd16;
  localparam logic [COST_W-1:0] COST_POP    = 5'd12;

  // Everything the sequencer needs about one accepted operation.
  typedef struct packed {
    logic              mem;
    logic              wr;
    logic              two;
    logic [ADDR_W-1:0] addr;
    logic              hl_upd;
    logic [ADDR_W-1:0] hl_val;
    logic              sp_upd;
    logic [ADDR_W-1:0] sp_val;
    logic [COST_W-1:0] cost;
  } lsu_plan_t;

endpackage

// File: rtl/lsu_wrap_add.sv
// Modulo-2^W adder; carry out is discarded on purpose.
module lsu_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  assign y = a + b;
endmodule

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hFF00
) (
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] bc,
  input  logic [ADDR_W-1:0] de,
  input  logic [ADDR_W-1:0] hl,
  input  logic [ADDR_W-1:0] sp,
  input  logic [BYTE_W-1:0] c_reg,
  input  logic [BYTE_W-1:0] imm8,
  input  logic [ADDR_W-1:0] imm16,
  output lsu_plan_t         plan
);
  // Adder slots: 0 HL+1, 1 HL-1, 2 SP-2, 3 SP+2, 4 high+imm8, 5 high+C
  localparam int N_ADD = 6;
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] MINUS1 = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] MINUS2 = ~ADDR_W'(1);

  logic [ADDR_W-1:0] add_a [N_ADD];
  logic [ADDR_W-1:0] add_b [N_ADD];
  logic [ADDR_W-1:0] add_y [N_ADD];

  always_comb begin
    add_a[0] = hl;        add_b[0] = ONE;
    add_a[1] = hl;        add_b[1] = MINUS1;
    add_a[2] = sp;        add_b[2] = MINUS2;
    add_a[3] = sp;        add_b[3] = TWO;
    add_a[4] = HIGH_BASE; add_b[4] = {{(ADDR_W-BYTE_W){1'b0}}, imm8};
    add_a[5] = HIGH_BASE; add_b[5] = {{(ADDR_W-BYTE_W){1'b0}}, c_reg};
  end

  for (genvar g = 0; g < N_ADD; g++) begin : g_add
    lsu_wrap_add #(.W(ADDR_W)) u_add (
      .a(add_a[g]),
      .b(add_b[g]),
      .y(add_y[g])
    );
  end

  always_comb begin
    plan      = '0;
    plan.cost = COST_REG;
    case (op)
      OP_MOVE: plan.cost = COST_REG;
      OP_IMM8: plan.cost = COST_IMM8;
      OP_RD_HL, OP_WR_HL: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_HL);
        plan.addr = hl;
        plan.cost = COST_PTR;
      end
      OP_WR_HL_IMM: begin
        plan.mem  = 1'b1;
        plan.wr   = 1'b1;
        plan.addr = hl;
        plan.cost = COST_HL_IMM;
      end
      OP_RD_BC, OP_WR_BC: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_BC);
        plan.addr = bc;
        plan.cost = COST_PTR;
      end
      OP_RD_DE, OP_WR_DE: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_DE);
        plan.addr = de;
        plan.cost = COST_PTR;
      end
      OP_RD_ABS, OP_WR_ABS: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_ABS);
        plan.addr = imm16;
        plan.cost = COST_ABS;
      end
      OP_RD_HI_IMM, OP_WR_HI_IMM: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_HI_IMM);
        plan.addr = add_y[4];
        plan.cost = COST_HI_IMM;
      end
      OP_RD_HI_C, OP_WR_HI_C: begin
        plan.mem  = 1'b1;
        plan.wr   = (op == OP_WR_HI_C);
        plan.addr = add_y[5];
        plan.cost = COST_HI_C;
      end
      OP_RD_HL_INC, OP_WR_HL_INC: begin
        plan.mem    = 1'b1;
        plan.wr     = (op == OP_WR_HL_INC);
        plan.addr   = hl;
        plan.hl_upd = 1'b1;
        plan.hl_val = add_y[0];
        plan.cost   = COST_PTR;
      end
      OP_RD_HL_DEC, OP_WR_HL_DEC: begin
        plan.mem    = 1'b1;
        plan.wr     = (op == OP_WR_HL_DEC);
        plan.addr   = hl;
        plan.hl_upd = 1'b1;
        plan.hl_val = add_y[1];
        plan.cost   = COST_PTR;
      end
      OP_PUSH: begin
        // pre-decrement: beats start at the new SP
        plan.mem    = 1'b1;
        plan.wr     = 1'b1;
        plan.two    = 1'b1;
        plan.addr   = add_y[2];
        plan.sp_upd = 1'b1;
        plan.sp_val = add_y[2];
        plan.cost   = COST_PUSH;
      end
      OP_POP: begin
        // post-increment: beats start at the old SP
        plan.mem    = 1'b1;
        plan.two    = 1'b1;
        plan.addr   = sp;
        plan.sp_upd = 1'b1;
        plan.sp_val = add_y[3];
        plan.cost   = COST_POP;
      end
      default: plan.cost = COST_REG;
    endcase
  end

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  lsu_plan_t         plan_in,
  output logic              idle,
  output logic              mem_en,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_hi,
  output logic              done,
  output logic              hl_we,
  output logic [ADDR_W-1:0] hl_val,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_val,
  output logic [COST_W-1:0] cost
);
  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND} phase_e;

  phase_e            phase;
  lsu_plan_t         plan_q;
  logic [ADDR_W-1:0] addr_next;
  logic              last;
  logic              active;

  lsu_wrap_add #(.W(ADDR_W)) u_next (
    .a(plan_q.addr),
    .b(ADDR_W'(1)),
    .y(addr_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      plan_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          plan_q <= plan_in;
          phase  <= PH_FIRST;
        end
        PH_FIRST: phase <= plan_q.two ? PH_SECOND : PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    idle     = (phase == PH_IDLE);
    active   = !idle;
    last     = (phase == PH_SECOND) || (phase == PH_FIRST && !plan_q.two);
    mem_en   = active && plan_q.mem;
    mem_wr   = mem_en && plan_q.wr;
    mem_hi   = mem_en && (phase == PH_SECOND);
    mem_addr = '0;
    if (mem_en) mem_addr = (phase == PH_SECOND) ? addr_next : plan_q.addr;
    done     = last;
    hl_we    = last && plan_q.hl_upd;
    hl_val   = hl_we ? plan_q.hl_val : '0;
    sp_we    = last && plan_q.sp_upd;
    sp_val   = sp_we ? plan_q.sp_val : '0;
    cost     = last ? plan_q.cost : '0;
  end

endmodule

// File: rtl/lsu_ea_unit.sv
module lsu_ea_unit
  import lsu_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HIGH_BASE = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [ADDR_W-1:0] in_bc,
  input  logic [ADDR_W-1:0] in_de,
  input  logic [ADDR_W-1:0] in_hl,
  input  logic [ADDR_W-1:0] in_sp,
  input  logic [BYTE_W-1:0] in_c,
  input  logic [BYTE_W-1:0] in_imm8,
  input  logic [ADDR_W-1:0] in_imm16,
  output logic              mem_en,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_hi,
  output logic              done,
  output logic              hl_we,
  output logic [ADDR_W-1:0] hl_val,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_val,
  output logic [COST_W-1:0] cost
);
  lsu_plan_t plan;
  logic      idle;
  logic      accept;

  assign in_ready = idle;
  assign accept   = in_valid && idle;

  lsu_decode #(.HIGH_BASE(HIGH_BASE)) u_dec (
    .op(in_op), .bc(in_bc), .de(in_de), .hl(in_hl), .sp(in_sp),
    .c_reg(in_c), .imm8(in_imm8), .imm16(in_imm16), .plan(plan)
  );

  lsu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .plan_in(plan),
    .idle(idle), .mem_en(mem_en), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_hi(mem_hi), .done(done), .hl_we(hl_we), .hl_val(hl_val),
    .sp_we(sp_we), .sp_val(sp_val), .cost(cost)
  );

endmodule

// File: rtl/lsu_ea_unit_chk.sv
module lsu_ea_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        mem_en,
  input logic        mem_wr,
  input logic [15:0] mem_addr,
  input logic        mem_hi,
  input logic        done,
  input logic        hl_we,
  input logic        sp_we
);
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_result_follows_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (mem_en || done));

  p_ready_after_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);

  p_done_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hl_only_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hl_we |-> done);

  p_sp_only_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> done);

  p_high_beat_wraps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hi |-> ($past(mem_en) && !$past(mem_hi) && !$past(done)
                && mem_addr == 16'($past(mem_addr) + 16'd1)));

  p_pair_same_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hi |-> (mem_wr == $past(mem_wr) && done));
endmodule

bind lsu_ea_unit lsu_ea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mem_en(mem_en), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_hi(mem_hi),
  .done(done), .hl_we(hl_we), .sp_we(sp_we)
);

// File: tb/lsu_ea_unit_test.sv
`timescale 1ns/1ps
module lsu_ea_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [15:0] in_bc = 16'h1234, in_de = 16'h5678, in_hl = '0, in_sp = '0;
  logic [7:0]  in_c = 8'h42, in_imm8 = 8'h80;
  logic [15:0] in_imm16 = 16'hBEEF;
  logic        mem_en, mem_wr, mem_hi, done, hl_we, sp_we;
  logic [15:0] mem_addr, hl_val, sp_val;
  logic [4:0]  cost;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lsu_ea_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_bc(in_bc), .in_de(in_de), .in_hl(in_hl), .in_sp(in_sp),
    .in_c(in_c), .in_imm8(in_imm8), .in_imm16(in_imm16),
    .mem_en(mem_en), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_hi(mem_hi),
    .done(done), .hl_we(hl_we), .hl_val(hl_val), .sp_we(sp_we),
    .sp_val(sp_val), .cost(cost)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] hl;
    logic [15:0] sp;
    logic        mem;
    logic        wr;
    logic [15:0] addr;
    logic        two;
    logic        hlwe;
    logic [15:0] hlv;
    logic        spwe;
    logic [15:0] spv;
    logic [4:0]  cost;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 26;
  // Shared operands: BC=1234 DE=5678 C=42 imm8=80 imm16=BEEF
  localparam vec_t VECS [NV] = '{
    '{5'd0,  16'h1000, 16'h2000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd4,  4'd2}, // R2 move
    '{5'd1,  16'h1000, 16'h2000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd2}, // R2 imm
    '{5'd2,  16'h1000, 16'h2000, 1'b1, 1'b0, 16'h1000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd3,  16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd4,  16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd12, 4'd3}, // R3
    '{5'd5,  16'h1000, 16'h2000, 1'b1, 1'b0, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd6,  16'h1000, 16'h2000, 1'b1, 1'b0, 16'h5678, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd7,  16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1234, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd8,  16'h1000, 16'h2000, 1'b1, 1'b1, 16'h5678, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd3}, // R3
    '{5'd9,  16'h1000, 16'h2000, 1'b1, 1'b0, 16'hBEEF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd16, 4'd4}, // R4
    '{5'd10, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'hBEEF, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd16, 4'd4}, // R4
    '{5'd11, 16'h1000, 16'h2000, 1'b1, 1'b0, 16'hFF80, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd12, 4'd5}, // R5
    '{5'd12, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'hFF80, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd12, 4'd5}, // R5
    '{5'd13, 16'h1000, 16'h2000, 1'b1, 1'b0, 16'hFF42, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd5}, // R5
    '{5'd14, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'hFF42, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd5}, // R5
    '{5'd15, 16'h1000, 16'h2000, 1'b1, 1'b0, 16'h1000, 1'b0, 1'b1, 16'h1001, 1'b0, 16'h0000, 5'd8,  4'd6}, // R6
    '{5'd16, 16'h1000, 16'h2000, 1'b1, 1'b0, 16'h1000, 1'b0, 1'b1, 16'h0FFF, 1'b0, 16'h0000, 5'd8,  4'd6}, // R6
    '{5'd17, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1000, 1'b0, 1'b1, 16'h1001, 1'b0, 16'h0000, 5'd8,  4'd6}, // R6
    '{5'd18, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1000, 1'b0, 1'b1, 16'h0FFF, 1'b0, 16'h0000, 5'd8,  4'd6}, // R6
    '{5'd19, 16'h1000, 16'h2000, 1'b1, 1'b1, 16'h1FFE, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h1FFE, 5'd16, 4'd7}, // R7
    '{5'd20, 16'h1000, 16'h2000, 1'b1, 1'b0, 16'h2000, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h2002, 5'd12, 4'd8}, // R8
    '{5'd17, 16'hFFFF, 16'h2000, 1'b1, 1'b1, 16'hFFFF, 1'b0, 1'b1, 16'h0000, 1'b0, 16'h0000, 5'd8,  4'd9}, // R9
    '{5'd16, 16'h0000, 16'h2000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 5'd8,  4'd9}, // R9
    '{5'd19, 16'h1000, 16'h0001, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 5'd16, 4'd9}, // R9
    '{5'd20, 16'h1000, 16'hFFFF, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0001, 5'd12, 4'd9}, // R9
    '{5'd25, 16'h1000, 16'h2000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 5'd4,  4'd2}  // R2 undefined
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Checks the done-cycle outputs of vector v.
  task automatic chk_done(input string rq, input vec_t v);
    chk(rq, "done", done, 1'b1);
    chk(rq, "hl_we", hl_we, v.hlwe);
    chk(rq, "hl_val", hl_val, v.hlwe ? v.hlv : 16'h0);
    chk(rq, "sp_we", sp_we, v.spwe);
    chk(rq, "sp_val", sp_val, v.spwe ? v.spv : 16'h0);
    chk(rq, "cost", cost, v.cost);
  endtask

  task automatic run_vec(input vec_t v, input bit scramble);
    string rq = $sformatf("R%0d", v.req);
    @(negedge clk);
    chk("R1", "ready idle", in_ready, 1'b1);
    in_op = v.op; in_hl = v.hl; in_sp = v.sp; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "ready busy", in_ready, 1'b0);
    chk(rq, "mem_en", mem_en, v.mem);
    chk(rq, "mem_wr", mem_wr, v.wr);
    chk(rq, "mem_addr", mem_addr, v.addr);
    chk(rq, "mem_hi", mem_hi, 1'b0);
    if (scramble) begin
      // R11: operand changes after accept must not matter
      in_op = 5'd3; in_hl = ~in_hl; in_sp = ~in_sp; in_bc = 16'hAAAA;
      in_de = 16'h5555; in_c = 8'h01; in_imm8 = 8'h02; in_imm16 = 16'h0F0F;
    end
    if (!v.two) begin
      chk_done(rq, v);
    end else begin
      chk("R10", "no early done", done, 1'b0);
      chk("R10", "cost quiet", cost, 5'd0);
      @(negedge clk);
      chk("R1", "ready busy hi", in_ready, 1'b0);
      chk(rq, "hi mem_en", mem_en, 1'b1);
      chk(rq, "hi mem_wr", mem_wr, v.wr);
      chk(rq, "hi mem_addr", mem_addr, 16'(v.addr + 16'd1));
      chk(rq, "hi mem_hi", mem_hi, 1'b1);
      chk_done(rq, v);
    end
    @(negedge clk);
    chk("R10", "done drops", done, 1'b0);
    chk("R1", "ready back", in_ready, 1'b1);
    in_bc = 16'h1234; in_de = 16'h5678; in_c = 8'h42; in_imm8 = 8'h80; in_imm16 = 16'hBEEF;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset ready", in_ready, 1'b1);
    chk("R10", "reset done", done, 1'b0);
    chk("R10", "reset mem_en", mem_en, 1'b0);
    chk("R10", "reset addr", mem_addr, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // R11: scrambled operands during push, pop and an HL-increment store
    run_vec(VECS[19], 1'b1);
    run_vec(VECS[20], 1'b1);
    run_vec(VECS[17], 1'b1);
    // R1: valid held low keeps the unit idle and quiet
    repeat (3) begin
      @(negedge clk);
      chk("R1", "idle no beat", mem_en, 1'b0);
      chk("R10", "idle no done", done, 1'b0);
    end
    // R1: a held request while busy is not taken twice
    @(negedge clk);
    in_op = 5'd2; in_hl = 16'h4444; in_valid = 1'b1;
    @(negedge clk);
    chk("R1", "first beat", mem_addr, 16'h4444);
    in_hl = 16'h7777;
    @(negedge clk);
    chk("R1", "gap after done", mem_en, 1'b0);
    chk("R1", "ready after done", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1", "second op new operand", mem_addr, 16'h7777);
    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R1 watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule